// File: doc/BRIEF.md
# Six-Source Interrupt Controller with Return-Stack Gating

This block collects interrupt requests from six sources of a small 8-bit microcontroller: two external pins, two timer/event counters, a time base and a real-time clock. It latches each request into a flag and merges the flags with per-source enables and one global enable. When a source is eligible, it raises an acknowledge together with a vector index. The core answers the acknowledge by pushing its program counter and branching to the vector for that source. The enables and flags sit together in two 8-bit control registers that the core reads and writes over a plain register port. The read data is combinational from the selected bank.

The global enable clears itself on every acknowledge. Nesting therefore happens only when the service routine sets it again, or when the core reports a return-from-interrupt. While the core reports that its return stack is full, nothing is acknowledged. Any latched flag drives a wake-up output, whatever the enable state.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, both banks read 0x00, `irq_ack` is 0 and `irq_wake` is 0.
- R2: Bank 0 layout: bit 0 is the global enable. Bits 1, 2 and 3 are the enables of ext0, ext1 and tmr0. Bits 4, 5 and 6 are the flags of ext0, ext1 and tmr0. Bit 7 reads 0.
- R3: Bank 1 layout: bits 0, 1 and 2 are the enables of tmr1, tbase and rtc. Bits 4, 5 and 6 are their flags. Bits 3 and 7 read 0 and ignore writes.
- R4: A high `irq_req` bit sets that source's flag on the clock edge, whatever the enables. Request index: 0 ext0, 1 ext1, 2 tmr0, 3 tmr1, 4 tbase, 5 rtc.
- R5: `irq_ack` is high in a cycle exactly when the global enable is set, some source has both its flag and its enable set, and `stack_full` is low. `irq_vec` then carries the request index of the chosen source.
- R6: When several sources are eligible, the pick order is ext0, tmr0, ext1, tmr1, tbase, rtc.
- R7: On an acknowledge edge, the global enable and the chosen source's flag clear, unless the same edge has a write to that bank or a new request for that source.
- R8: While `stack_full` is high, `irq_ack` stays low even with an eligible source.
- R9: A `reti` pulse sets the global enable, unless the same edge has an acknowledge or a bank-0 write.
- R10: `irq_wake` is high exactly when at least one flag is set.
- R11: On any edge, a request beats a software write of 0 to its flag. A software write of 1 sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_bank | input | 1 | Bank select: 0 or 1 |
| reg_wr | input | 1 | Write strobe for the selected bank |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected bank |
| irq_req | input | 6 | Per-source request pulses |
| stack_full | input | 1 | Core return stack is full |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_ack | output | 1 | Acknowledge: push PC and branch |
| irq_vec | output | 3 | Request index of the acknowledged source |
| irq_wake | output | 1 | Wake-up: some flag is set |

## Verification
On every cycle, the assertions check the following:
- a full stack blocks the acknowledge, and an acknowledge requires the global enable;
- at most one source is granted;
- after an acknowledge the global enable and the granted flag drop;
- a request raises the wake-up line;
- `reti` restores the global enable.

The bench scenarios cover the rest:
- the bit layout of both banks and the read-as-zero bits;
- the exact pick order when several sources compete;
- a request beating a software clear;
- the nesting sequence, in which software re-arms the enables inside a handler.

// File: rtl/irq_pkg.sv
// Shared constants and helpers for the interrupt controller.
// Assumes exactly two banks of three sources each; bit layout is computed.
package irq_pkg;
    localparam int NSRC = 6;
    localparam int DW   = 8;
    localparam int HALF = NSRC / 2;
    localparam int IDXW = $clog2(NSRC);

    typedef enum logic [IDXW-1:0] {
        SRC_EXT0  = 3'd0,
        SRC_EXT1  = 3'd1,
        SRC_TMR0  = 3'd2,
        SRC_TMR1  = 3'd3,
        SRC_TBASE = 3'd4,
        SRC_RTC   = 3'd5
    } src_e;

    // Source served at a given priority rank (rank 0 wins).
    function automatic int rank_src(input int r);
        case (r)
            0: return int'(SRC_EXT0);
            1: return int'(SRC_TMR0);
            2: return int'(SRC_EXT1);
            3: return int'(SRC_TMR1);
            4: return int'(SRC_TBASE);
            default: return int'(SRC_RTC);
        endcase
    endfunction

    // Bank holding a source.
    function automatic int src_bank(input int s);
        return s / HALF;
    endfunction

    // Enable bit position: bank 0 is shifted up by one for the global enable.
    function automatic int en_bit(input int s);
        return (s < HALF) ? s + 1 : s - HALF;
    endfunction

    // Flag bit position: upper nibble in both banks.
    function automatic int flag_bit(input int s);
        return 4 + (s % HALF);
    endfunction
endpackage

// File: rtl/irq_regs.sv
// Control register storage: global enable, per-source enables and flags.
// Assumes hw_set and ack_clr are one-cycle pulses; ack_clr is one-hot or zero.
// Priority per flag: request set > software write > acknowledge clear.
module irq_regs
    import irq_pkg::*;
#(
    parameter int N = NSRC,
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bank,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] ack_clr,
    input  logic         ack_take,
    input  logic         reti,
    output logic         glob_en,
    output logic [N-1:0] src_en,
    output logic [N-1:0] src_flag,
    output logic [W-1:0] rdata
);
    logic wr0;
    assign wr0 = wr && !bank;

    // Global enable: bank-0 write, then acknowledge clear, then reti set.
    always_ff @(posedge clk) begin
        if (!rst_n)        glob_en <= 1'b0;
        else if (wr0)      glob_en <= wdata[0];
        else if (ack_take) glob_en <= 1'b0;
        else if (reti)     glob_en <= 1'b1;
    end

    for (genvar s = 0; s < N; s++) begin : g_src
        localparam int BK = src_bank(s);
        localparam int EB = en_bit(s);
        localparam int FB = flag_bit(s);
        logic hit, en_q, fl_q;
        assign hit = wr && (int'(bank) == BK);

        // Per-source enable and request flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= 1'b0;
                fl_q <= 1'b0;
            end else begin
                if (hit) en_q <= wdata[EB];
                if (hw_set[s])       fl_q <= 1'b1;
                else if (hit)        fl_q <= wdata[FB];
                else if (ack_clr[s]) fl_q <= 1'b0;
            end
        end
        assign src_en[s]   = en_q;
        assign src_flag[s] = fl_q;
    end

    // Read mux: assemble the selected bank, unused bits stay zero.
    always_comb begin
        rdata = '0;
        if (!bank) rdata[0] = glob_en;
        for (int s = 0; s < N; s++) begin
            if (src_bank(s) == int'(bank)) begin
                rdata[en_bit(s)]   = src_en[s];
                rdata[flag_bit(s)] = src_flag[s];
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority picker over eligible sources.
// Assumes the rank order from irq_pkg::rank_src; outputs are combinational.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int IW = IDXW
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // Walk ranks from highest priority, grant the first request found.
    always_comb begin
        grant = '0;
        valid = 1'b0;
        for (int r = 0; r < N; r++) begin
            if (!valid && req[rank_src(r)]) begin
                grant[rank_src(r)] = 1'b1;
                valid = 1'b1;
            end
        end
    end

    // Encode the granted source into its request index.
    always_comb begin
        idx = '0;
        for (int s = 0; s < N; s++)
            if (grant[s]) idx = IW'(s);
    end
endmodule

// File: rtl/irq_ctrl.sv
// Interrupt controller top: latches six requests, gates them with enables,
// the global enable and return-stack status, and issues acknowledge + vector.
// Assumes the core pushes its PC and branches in the cycle irq_ack is high.
module irq_ctrl
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_bank,
    input  logic            reg_wr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NSRC-1:0] irq_req,
    input  logic            stack_full,
    input  logic            reti,
    output logic            irq_ack,
    output logic [IDXW-1:0] irq_vec,
    output logic            irq_wake
);
    logic            glob_en;
    logic [NSRC-1:0] src_en, src_flag, eligible, grant;

    irq_regs #(.N(NSRC), .W(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank     (reg_bank),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .hw_set   (irq_req),
        .ack_clr  (grant),
        .ack_take (irq_ack),
        .reti     (reti),
        .glob_en  (glob_en),
        .src_en   (src_en),
        .src_flag (src_flag),
        .rdata    (reg_rdata)
    );

    // Eligibility: flag, enable, global enable, and room on the stack.
    assign eligible = (glob_en && !stack_full) ? (src_flag & src_en) : '0;

    irq_arbiter #(.N(NSRC), .IW(IDXW)) u_arb (
        .req   (eligible),
        .grant (grant),
        .valid (irq_ack),
        .idx   (irq_vec)
    );

    assign irq_wake = |src_flag;
endmodule

// File: rtl/irq_ctrl_checker.sv
// Protocol checker for irq_ctrl, attached by bind.
module irq_ctrl_checker
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            reg_bank,
    input logic            reg_wr,
    input logic [NSRC-1:0] irq_req,
    input logic            stack_full,
    input logic            reti,
    input logic            irq_ack,
    input logic            irq_wake,
    input logic            glob_en,
    input logic [NSRC-1:0] src_flag,
    input logic [NSRC-1:0] grant
);
    a_r8_stack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stack_full |-> !irq_ack);

    a_r5_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> glob_en);

    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r7_global_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(reg_wr && !reg_bank)) |=> !glob_en);

    a_r7_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !reg_wr && irq_req == '0) |=> ((src_flag & $past(grant)) == '0));

    a_r4_wake_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |=> irq_wake);

    a_r9_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !irq_ack && !(reg_wr && !reg_bank)) |=> glob_en);
endmodule

bind irq_ctrl irq_ctrl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_bank   (reg_bank),
    .reg_wr     (reg_wr),
    .irq_req    (irq_req),
    .stack_full (stack_full),
    .reti       (reti),
    .irq_ack    (irq_ack),
    .irq_wake   (irq_wake),
    .glob_en    (glob_en),
    .src_flag   (src_flag),
    .grant      (grant)
);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_bank = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] irq_req = '0;
    logic       stack_full = 1'b0, reti = 1'b0;
    logic       irq_ack, irq_wake;
    logic [2:0] irq_vec;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    // Reference model state
    logic       gie_m = 1'b0;
    logic [5:0] en_m = '0, fl_m = '0;

    always #2 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_bank(reg_bank), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .stack_full(stack_full), .reti(reti), .irq_ack(irq_ack),
        .irq_vec(irq_vec), .irq_wake(irq_wake)
    );

    function automatic int bank_of(int s);  return s / 3; endfunction
    function automatic int ebit(int s);     return (s < 3) ? s + 1 : s - 3; endfunction
    function automatic int fbit(int s);     return 4 + (s % 3); endfunction

    // R6 order: ext0, tmr0, ext1, tmr1, tbase, rtc
    function automatic int pick(logic [5:0] e);
        int ord [6] = '{0, 2, 1, 3, 4, 5};
        for (int r = 0; r < 6; r++) if (e[ord[r]]) return ord[r];
        return -1;
    endfunction

    function automatic logic [7:0] exp_rd(logic b);
        logic [7:0] r = '0;
        if (!b) r[0] = gie_m;
        for (int s = 0; s < 6; s++)
            if (bank_of(s) == int'(b)) begin
                r[ebit(s)] = en_m[s];
                r[fbit(s)] = fl_m[s];
            end
        return r;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check outputs, update model at posedge.
    task automatic step(string tag, logic b, logic w, logic [7:0] wd,
                        logic [5:0] rq, logic sf, logic rt);
        logic [5:0] e;
        int p;
        logic [5:0] fl_n, en_n;
        logic gie_n;
        @(negedge clk);
        reg_bank = b; reg_wr = w; reg_wdata = wd; irq_req = rq;
        stack_full = sf; reti = rt;
        #1;
        e = (gie_m && !sf) ? (fl_m & en_m) : 6'b0;
        p = pick(e);
        chk(tag, "ack R5", int'(irq_ack), int'(p >= 0));
        if (p >= 0) chk(tag, "vec R6", int'(irq_vec), p);
        chk(tag, b ? "rdata R3" : "rdata R2", int'(reg_rdata), int'(exp_rd(b)));
        chk(tag, "wake R10", int'(irq_wake), int'(|fl_m));
        @(posedge clk);
        fl_n = fl_m; en_n = en_m;
        for (int s = 0; s < 6; s++) begin
            logic hit = w && (bank_of(s) == int'(b));
            if (rq[s])        fl_n[s] = 1'b1;
            else if (hit)     fl_n[s] = wd[fbit(s)];
            else if (p == s)  fl_n[s] = 1'b0;
            if (hit) en_n[s] = wd[ebit(s)];
        end
        if (w && !b)      gie_n = wd[0];
        else if (p >= 0)  gie_n = 1'b0;
        else if (rt)      gie_n = 1'b1;
        else              gie_n = gie_m;
        fl_m = fl_n; en_m = en_n; gie_m = gie_n;
    endtask

    task automatic idle(string tag, logic b);
        step(tag, b, 1'b0, 8'h00, 6'h00, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h1F3A));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state on both banks
        idle("R1", 1'b0);
        idle("R1", 1'b1);
        // R3: unused bits of bank 1 ignore writes
        step("R3", 1'b1, 1'b1, 8'hFF, 6'h00, 1'b0, 1'b0);
        idle("R3", 1'b1);
        step("R3", 1'b1, 1'b1, 8'h00, 6'h00, 1'b0, 1'b0);
        // R2: bank 0 layout, enables only
        step("R2", 1'b0, 1'b1, 8'h8E, 6'h00, 1'b0, 1'b0);
        idle("R2", 1'b0);
        // R4: request latches with global enable off, no ack
        step("R4", 1'b0, 1'b0, 8'h00, 6'b000100, 1'b0, 1'b0);
        idle("R4", 1'b0);
        // R11: request beats software clear in the same edge
        step("R11", 1'b0, 1'b1, 8'h0E, 6'b000001, 1'b0, 1'b0);
        idle("R11", 1'b0);
        // R8: global enable set, but stack full holds off
        step("R8", 1'b0, 1'b1, 8'h5F, 6'h00, 1'b1, 1'b0);
        step("R8", 1'b0, 1'b0, 8'h00, 6'h00, 1'b1, 1'b0);
        // R6/R7: sources served in order, reti re-arms (R9)
        step("R11", 1'b1, 1'b1, 8'h77, 6'h00, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) begin
            idle("R7", 1'b0);
            step("R9", 1'b0, 1'b0, 8'h00, 6'h00, 1'b0, 1'b1);
        end
        idle("R10", 1'b1);
        // Randomized mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            step("R5", r[0], (r[3:1] == 3'd0), r[11:4],
                 (r[15:12] == 4'd0) ? r[21:16] : 6'h00,
                 (r[23:22] == 2'd0), (r[27:24] == 4'd0));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule